// File: doc/BRIEF.md
# Dual-Rate Serial Command Slave

This block is the device side of a three-wire serial link made of a chip select, a host clock and one shared data line. It treats the host clock as its own clock. Every access opens with a five-bit command and continues with a data phase. Short accesses carry 16 data bits at one clock per bit. Long accesses carry 46 data bits, and each bit lasts four clocks so that a slow one-time-programmable (OTP) store has time to follow. The shared line is presented as three plain signals: serial input, serial output and a separate output enable. The surrounding pad logic merges them into the bidirectional line.

Short write accesses load a configuration word. That word sets a low-power sleep level, issues a one-clock global reset pulse, routes the channels to a test bus and bypasses the output buffer. A short program-enable access unlocks the long commands. Those commands hand a 46-bit word and a strobe to an OTP controller, or they stream the controller's read word back to the host. When chip select is low, all frame state is held cleared. The configuration and the unlock flag survive until the power-on reset `rst_n`.

Top module: `sss_slave`

## Requirements
- R1: Each frame sends its command bits and then its data bits, most significant bit first in both cases. Every bit is sampled on a rising clock edge while `sel` is high, and the first edge with `sel` high takes command bit 4.
- R2: Config write (command 10111) uses 16 data bits at one clock each. Counting the first edge of the frame as edge 0, the word takes effect on edge 20.
- R3: In the config word, bit 15 gives the `sleep` level, bit 9 gives `test_route` and bit 8 gives `buf_bypass`. These levels hold until the next completed config write or until `rst_n`.
- R4: Config bit 14 makes `glob_rst` high for exactly one cycle after the commit edge. The bit is not stored.
- R5: Program enable (command 10000, 16 data bits, data ignored) sets `prog_en` at the end of its data phase. The flag then stays set until `rst_n`.
- R6: OTP write (11111) and OTP program (11001) each carry 46 data bits of four clocks each, sampled on the fourth clock of each bit. After edge 188 the word appears on `otp_wdata`, with a one-cycle `otp_wr_stb` for OTP write or `otp_prog_stb` for OTP program.
- R7: OTP read (01111) captures `otp_rdata` on edge 4, the edge of the last command bit, and raises `sdo_oe` after that edge. It then presents the word most significant bit first, holding each bit for four clocks. After the last bit it drives 0 until `sel` falls.
- R8: OTP analog readback (01001) behaves like OTP read. In addition, `otp_ana_active` is high from edge 4 until `sel` falls.
- R9: `sdo_oe` is low during the command phase and during write frames. It drops as soon as `sel` goes low. A frame cut short by `sel` falling commits nothing.
- R10: Any other command code runs a 16-bit data phase that changes no output and never drives the line.
- R11: While `prog_en` is low, the four long commands keep their 46×4 timing but produce no strobe, no drive and no `otp_ana_active`.
- R12: After `rst_n`, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host serial clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sel | input | 1 | Chip select, active high; low clears the frame logic |
| sdi | input | 1 | Serial data from the shared line |
| sdo | output | 1 | Serial data to the shared line |
| sdo_oe | output | 1 | Output enable for the shared line |
| otp_rdata | input | 46 | Word supplied by the OTP controller for reads |
| otp_wdata | output | 46 | Word delivered to the OTP controller |
| otp_wr_stb | output | 1 | One-cycle OTP write strobe |
| otp_prog_stb | output | 1 | One-cycle OTP program strobe |
| otp_ana_active | output | 1 | High during an analog readback data phase |
| sleep | output | 1 | Low-power level |
| glob_rst | output | 1 | One-cycle global reset pulse |
| test_route | output | 1 | Route channels to the test bus |
| buf_bypass | output | 1 | Bypass the output buffer |
| prog_en | output | 1 | Long commands unlocked |

## Verification
All timing is counted in edges from the first rising edge with `sel` high. Drive starts after edge 4. The read bit for slot s appears after edge 4+4s. Short commits land on edge 20 and long commits on edge 188, and a pulse is gone one edge later. The bench model drives each bit on the falling edge. It compares the enable, the data and the readback flag at every falling edge against values computed from these edge numbers. It samples the commit outputs at the falling edge after the final edge, and again one cycle later to confirm the pulses last a single cycle.

// File: rtl/sss_pkg.sv
package sss_pkg;
   typedef enum logic [2:0] {
      OP_NONE, OP_CFG, OP_PEN, OP_OWR, OP_OPRG, OP_ORD, OP_OANA
   } op_e;

   typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_END} phase_e;

   localparam logic [4:0] CODE_CFG  = 5'b10111;
   localparam logic [4:0] CODE_PEN  = 5'b10000;
   localparam logic [4:0] CODE_OWR  = 5'b11111;
   localparam logic [4:0] CODE_OPRG = 5'b11001;
   localparam logic [4:0] CODE_ORD  = 5'b01111;
   localparam logic [4:0] CODE_OANA = 5'b01001;
endpackage

// File: rtl/sss_cmd_decode.sv
module sss_cmd_decode
   import sss_pkg::*;
#(
   parameter int CMD_W = 5
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic             unlocked,
   output op_e              op,
   output logic             ext,
   output logic             rd
);
   always_comb begin
      ext = (cmd == CODE_OWR) || (cmd == CODE_OPRG) ||
            (cmd == CODE_ORD) || (cmd == CODE_OANA);
      op  = OP_NONE;
      case (cmd)
         CODE_CFG:  op = OP_CFG;
         CODE_PEN:  op = OP_PEN;
         CODE_OWR:  op = unlocked ? OP_OWR  : OP_NONE;
         CODE_OPRG: op = unlocked ? OP_OPRG : OP_NONE;
         CODE_ORD:  op = unlocked ? OP_ORD  : OP_NONE;
         CODE_OANA: op = unlocked ? OP_OANA : OP_NONE;
         default:   op = OP_NONE;
      endcase
      rd = (op == OP_ORD) || (op == OP_OANA);
   end
endmodule

// File: rtl/sss_frame_seq.sv
module sss_frame_seq
   import sss_pkg::*;
#(
   parameter int CMD_W   = 5,
   parameter int NRM_W   = 16,
   parameter int EXT_W   = 46,
   parameter int EXT_CPB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             sdi,
   input  logic             ext_in,
   output logic [CMD_W-1:0] cmd_word,
   output logic             cmd_last,
   output logic             slot_end,
   output logic             last_slot
);
   localparam int DW    = (EXT_W > NRM_W) ? EXT_W : NRM_W;
   localparam int BW    = $clog2(DW);
   localparam int CCW   = $clog2(CMD_W);
   localparam int SUB_W = (EXT_CPB > 1) ? $clog2(EXT_CPB) : 1;

   phase_e             phase;
   logic [CMD_W-2:0]   csr;
   logic [CCW-1:0]     ccnt;
   logic [BW-1:0]      bcnt;
   logic               ext_q;
   logic               slot_tick;
   logic               in_data;

   assign cmd_word  = {csr, sdi};
   assign in_data   = (phase == PH_DATA);
   assign cmd_last  = sel && (phase == PH_CMD) && (ccnt == CCW'(CMD_W-1));
   assign slot_end  = in_data && (!ext_q || slot_tick);
   assign last_slot = (bcnt == '0);

   generate
      if (EXT_CPB == 1) begin : g_single
         assign slot_tick = 1'b1;
      end else begin : g_multi
         logic [SUB_W-1:0] subq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               subq <= '0;
            else if (!sel || !in_data)
               subq <= '0;
            else if (subq == SUB_W'(EXT_CPB-1))
               subq <= '0;
            else
               subq <= subq + 1'b1;
         end
         assign slot_tick = (subq == SUB_W'(EXT_CPB-1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CMD;
         csr   <= '0;
         ccnt  <= '0;
         bcnt  <= '0;
         ext_q <= 1'b0;
      end else if (!sel) begin
         phase <= PH_CMD;
         csr   <= '0;
         ccnt  <= '0;
         bcnt  <= '0;
         ext_q <= 1'b0;
      end else begin
         case (phase)
            PH_CMD: begin
               csr  <= {csr[CMD_W-3:0], sdi};
               ccnt <= ccnt + 1'b1;
               if (ccnt == CCW'(CMD_W-1)) begin
                  phase <= PH_DATA;
                  ext_q <= ext_in;
                  bcnt  <= ext_in ? BW'(EXT_W-1) : BW'(NRM_W-1);
               end
            end
            PH_DATA: begin
               if (slot_end) begin
                  if (last_slot) phase <= PH_END;
                  else           bcnt  <= bcnt - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sss_shift_reg.sv
module sss_shift_reg #(
   parameter int DW = 46
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          shift,
   input  logic          sin,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!sel)  q <= '0;
      else if (load)  q <= load_val;
      else if (shift) q <= {q[DW-2:0], sin};
   end
endmodule

// File: rtl/sss_slave.sv
module sss_slave
   import sss_pkg::*;
#(
   parameter int CMD_W     = 5,
   parameter int NRM_W     = 16,
   parameter int EXT_W     = 46,
   parameter int EXT_CPB   = 4,
   parameter int SLEEP_BIT = 15,
   parameter int GRST_BIT  = 14,
   parameter int TEST_BIT  = 9,
   parameter int BYP_BIT   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             sdi,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic [EXT_W-1:0] otp_rdata,
   output logic [EXT_W-1:0] otp_wdata,
   output logic             otp_wr_stb,
   output logic             otp_prog_stb,
   output logic             otp_ana_active,
   output logic             sleep,
   output logic             glob_rst,
   output logic             test_route,
   output logic             buf_bypass,
   output logic             prog_en
);
   generate
      if (CMD_W != 5) begin : g_bad_cmd
         $error("sss_slave: command codes are five bits wide");
      end
      if (EXT_W < NRM_W) begin : g_bad_ext
         $error("sss_slave: long data phase must not be shorter than short one");
      end
      if (EXT_CPB < 1) begin : g_bad_cpb
         $error("sss_slave: clocks per long bit must be at least one");
      end
      if (SLEEP_BIT >= NRM_W || GRST_BIT >= NRM_W ||
          TEST_BIT >= NRM_W || BYP_BIT >= NRM_W) begin : g_bad_bit
         $error("sss_slave: config bit position outside short data word");
      end
   endgenerate

   logic [CMD_W-1:0] cmd_word;
   logic             cmd_last, slot_end, last_slot;
   op_e              op_dec, op_q;
   logic             ext_dec, rd_dec;
   logic             oe_q;
   logic [EXT_W-1:0] sh_q;
   logic [EXT_W-1:0] word;
   logic             commit;

   sss_cmd_decode #(.CMD_W(CMD_W)) u_dec (
      .cmd      (cmd_word),
      .unlocked (prog_en),
      .op       (op_dec),
      .ext      (ext_dec),
      .rd       (rd_dec)
   );

   sss_frame_seq #(
      .CMD_W(CMD_W), .NRM_W(NRM_W), .EXT_W(EXT_W), .EXT_CPB(EXT_CPB)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .sdi       (sdi),
      .ext_in    (ext_dec),
      .cmd_word  (cmd_word),
      .cmd_last  (cmd_last),
      .slot_end  (slot_end),
      .last_slot (last_slot)
   );

   sss_shift_reg #(.DW(EXT_W)) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .load     (cmd_last && rd_dec),
      .load_val (otp_rdata),
      .shift    (slot_end),
      .sin      (oe_q ? 1'b0 : sdi),
      .q        (sh_q)
   );

   // frame-scoped state: cleared whenever chip select is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_NONE;
         oe_q <= 1'b0;
      end else if (!sel) begin
         op_q <= OP_NONE;
         oe_q <= 1'b0;
      end else if (cmd_last) begin
         op_q <= op_dec;
         oe_q <= rd_dec;
      end
   end

   assign word           = {sh_q[EXT_W-2:0], sdi};
   assign commit         = sel && slot_end && last_slot;
   assign sdo_oe         = oe_q && sel;
   assign sdo            = oe_q && sh_q[EXT_W-1];
   assign otp_ana_active = sel && (op_q == OP_OANA);

   // persistent state: survives chip select, cleared only by power-on reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep        <= 1'b0;
         glob_rst     <= 1'b0;
         test_route   <= 1'b0;
         buf_bypass   <= 1'b0;
         prog_en      <= 1'b0;
         otp_wdata    <= '0;
         otp_wr_stb   <= 1'b0;
         otp_prog_stb <= 1'b0;
      end else begin
         glob_rst     <= 1'b0;
         otp_wr_stb   <= 1'b0;
         otp_prog_stb <= 1'b0;
         if (commit) begin
            case (op_q)
               OP_CFG: begin
                  sleep      <= word[SLEEP_BIT];
                  glob_rst   <= word[GRST_BIT];
                  test_route <= word[TEST_BIT];
                  buf_bypass <= word[BYP_BIT];
               end
               OP_PEN:  prog_en <= 1'b1;
               OP_OWR: begin
                  otp_wdata  <= word;
                  otp_wr_stb <= 1'b1;
               end
               OP_OPRG: begin
                  otp_wdata    <= word;
                  otp_prog_stb <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sss_slave_chk.sv
module sss_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic sel,
   input logic sdo_oe,
   input logic otp_wr_stb,
   input logic otp_prog_stb,
   input logic otp_ana_active,
   input logic glob_rst,
   input logic prog_en
);
   // R9: first edge of a frame is a command edge, line not driven
   a_r9_quiet_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel) |-> !sdo_oe);

   // R4: the reset pulse lasts one cycle
   a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      glob_rst |=> !glob_rst);

   // R6: strobes are exclusive and each lasts one cycle
   a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({otp_wr_stb, otp_prog_stb}));
   a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      otp_wr_stb |=> !otp_wr_stb);
   a_r6_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
      otp_prog_stb |=> !otp_prog_stb);

   // R11: no OTP strobe without the unlock flag
   a_r11_strobe_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (otp_wr_stb || otp_prog_stb) |-> prog_en);

   // R5: unlock flag is sticky
   a_r5_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |=> prog_en);

   // R8: readback flag only while the line is driven
   a_r8_ana_driven: assert property (@(posedge clk) disable iff (!rst_n)
      otp_ana_active |-> sdo_oe);
endmodule

bind sss_slave sss_slave_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sel            (sel),
   .sdo_oe         (sdo_oe),
   .otp_wr_stb     (otp_wr_stb),
   .otp_prog_stb   (otp_prog_stb),
   .otp_ana_active (otp_ana_active),
   .glob_rst       (glob_rst),
   .prog_en        (prog_en)
);

// File: tb/sss_slave_bench.sv
module sss_slave_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        sdi = 1'b0;
   logic        sdo, sdo_oe;
   logic [45:0] otp_rdata = '0;
   logic [45:0] otp_wdata;
   logic        otp_wr_stb, otp_prog_stb, otp_ana_active;
   logic        sleep, glob_rst, test_route, buf_bypass, prog_en;

   int errs = 0;
   int checks = 0;
   logic end_rst, end_wr, end_prg, aft_rst, aft_wr, aft_prg;

   always #4 clk = ~clk;

   sss_slave u_sss_slave (
      .clk(clk), .rst_n(rst_n), .sel(sel), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .otp_rdata(otp_rdata), .otp_wdata(otp_wdata), .otp_wr_stb(otp_wr_stb),
      .otp_prog_stb(otp_prog_stb), .otp_ana_active(otp_ana_active),
      .sleep(sleep), .glob_rst(glob_rst), .test_route(test_route),
      .buf_bypass(buf_bypass), .prog_en(prog_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural model: edge k of a frame, k=0 first edge with sel high.
   task automatic run_frame(input logic [4:0] cmd, input logic [45:0] wd,
                            input int nb, input int cpb, input bit drv,
                            input logic [45:0] rexp, input bit ana,
                            input int stop_at);
      int last = 4 + nb * cpb;
      @(negedge clk);
      sel = 1'b1;
      sdi = cmd[4];
      for (int k = 0; k <= last; k++) begin
         @(posedge clk);
         @(negedge clk);
         begin
            bit e_oe = drv && (k >= 4);
            chk(sdo_oe == e_oe, drv ? "R7" : "R9", "sdo_oe", sdo_oe, e_oe);
            if (e_oe) begin
               int s = (k - 4) / cpb;
               logic e_d = (s < nb) ? rexp[nb-1-s] : 1'b0;
               chk(sdo == e_d, "R7", "sdo bit", sdo, e_d);
            end
            chk(otp_ana_active == (ana && k >= 4), "R8", "otp_ana_active",
                otp_ana_active, ana && k >= 4);
         end
         if (k == stop_at) begin
            sel = 1'b0;
            #1;
            chk(!sdo_oe, "R9", "release on abort", sdo_oe, 0);
            return;
         end
         if (k == last) begin
            end_rst = glob_rst; end_wr = otp_wr_stb; end_prg = otp_prog_stb;
         end else begin
            int n = k + 1;
            sdi = (n < 5) ? cmd[4-n] : (drv ? 1'b0 : wd[nb-1-(n-5)/cpb]);
         end
      end
      @(posedge clk);
      @(negedge clk);
      aft_rst = glob_rst; aft_wr = otp_wr_stb; aft_prg = otp_prog_stb;
      sel = 1'b0;
      #1;
      chk(!sdo_oe, "R9", "release on sel low", sdo_oe, 0);
   endtask

   initial begin
      #(8 * 200000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [45:0] wa = 46'h2BCD_EF01_2345;
      logic [45:0] wb = 46'h1357_9BDF_0246;
      logic [45:0] ra = 46'h3A5C_0F96_E1B7;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk({sdo_oe, sleep, glob_rst, test_route, buf_bypass, prog_en,
           otp_wr_stb, otp_prog_stb, otp_ana_active} == 0, "R12", "outputs",
          {sdo_oe, sleep, glob_rst, test_route, buf_bypass, prog_en}, 0);
      chk(otp_wdata == 0, "R12", "otp_wdata", otp_wdata, 0);
      rst_n = 1'b1;

      // R1 R2 R3: config write with bits 15, 9, 8
      run_frame(5'b10111, 46'h8300, 16, 1, 0, 0, 0, -1);
      chk(sleep, "R3", "sleep", sleep, 1);
      chk(test_route, "R3", "test_route", test_route, 1);
      chk(buf_bypass, "R3", "buf_bypass", buf_bypass, 1);
      chk(!end_rst, "R4", "no reset pulse", end_rst, 0);

      // R4: reset pulse, other bits cleared
      run_frame(5'b10111, 46'h4000, 16, 1, 0, 0, 0, -1);
      chk(end_rst, "R4", "pulse at commit", end_rst, 1);
      chk(!aft_rst, "R4", "pulse gone", aft_rst, 0);
      chk({sleep, test_route, buf_bypass} == 0, "R2", "cleared cfg",
          {sleep, test_route, buf_bypass}, 0);

      // R9: aborted config frame commits nothing
      run_frame(5'b10111, 46'hFFFF, 16, 1, 0, 0, 0, 12);
      @(negedge clk);
      chk({sleep, test_route, buf_bypass, glob_rst} == 0, "R9", "abort no commit",
          {sleep, test_route, buf_bypass, glob_rst}, 0);

      // R10: unknown write and unknown read
      run_frame(5'b10101, 46'hFFFF, 16, 1, 0, 0, 0, -1);
      chk({sleep, test_route, buf_bypass, end_rst, prog_en} == 0, "R10",
          "unknown write", {sleep, test_route, buf_bypass, end_rst, prog_en}, 0);
      run_frame(5'b00011, 46'h0, 16, 1, 0, 0, 0, -1);

      // R11: long commands while locked
      otp_rdata = ra;
      run_frame(5'b11111, wa, 46, 4, 0, 0, 0, -1);
      chk(!end_wr && otp_wdata == 0, "R11", "locked write", otp_wdata, 0);
      run_frame(5'b01001, 46'h0, 46, 4, 0, 0, 0, -1);

      // R5: unlock
      chk(!prog_en, "R5", "locked before", prog_en, 0);
      run_frame(5'b10000, 46'h0, 16, 1, 0, 0, 0, -1);
      chk(prog_en, "R5", "unlocked", prog_en, 1);

      // R6: OTP write then OTP program
      run_frame(5'b11111, wa, 46, 4, 0, 0, 0, -1);
      chk(end_wr && !end_prg, "R6", "write strobe", {end_wr, end_prg}, 2'b10);
      chk(!aft_wr, "R6", "write strobe gone", aft_wr, 0);
      chk(otp_wdata == wa, "R6", "write word", otp_wdata, wa);
      run_frame(5'b11001, wb, 46, 4, 0, 0, 0, -1);
      chk(end_prg && !end_wr, "R6", "program strobe", {end_wr, end_prg}, 2'b01);
      chk(!aft_prg, "R6", "program strobe gone", aft_prg, 0);
      chk(otp_wdata == wb, "R6", "program word", otp_wdata, wb);

      // R7 R8: reads
      run_frame(5'b01111, 46'h0, 46, 4, 1, ra, 0, -1);
      otp_rdata = ~ra;
      run_frame(5'b01001, 46'h0, 46, 4, 1, ~ra, 1, -1);

      // R5: still unlocked, config still works
      run_frame(5'b10111, 46'h0100, 16, 1, 0, 0, 0, -1);
      chk(prog_en && buf_bypass && !sleep, "R5", "sticky unlock",
          {prog_en, buf_bypass, sleep}, 3'b110);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule